// File: doc/BRIEF.md
# Vectored 64-input interrupt controller

This block gathers 64 interrupt inputs and steers each one to one of 64 outgoing interrupt lines. Each input is set to edge or level mode and can be masked. For every input the block keeps a pending-request bit and an in-service bit. A rising input whose request is pending and unmasked enters service. It then raises the outgoing line named by its byte in a programmable vector table. That line stays high until the input falls, is masked, or is retired by software.

Software reaches the block through a single-cycle 32-bit register port. There is no stream traffic, so the port has no valid/ready pair and no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` follows `reg_addr` combinationally, and every read completes in the same cycle. Every 64-bit register appears as a low word and a high word. The vector table and a route table are reached one byte per address.

Top module: `irq_vector_ctl`

## Requirements
- R1: Mode register (0x060 low word, 0x064 high word), bit = 1 selects edge mode. An edge-mode input latches its request on a low-to-high change, and the request stays set after the input falls. A level-mode input's request equals the input level sampled at the previous edge.
- R2: When an input rises while its request is set and its mask bit is 0, it enters service at that clock edge. Output line `irq_out[v]` goes high, where v is the input's vector byte. A vector value of 64 or more drives no line.
- R3: When an input falls, its in-service bit is cleared at that edge, and its output line drops unless another in-service input shares that vector.
- R4: A mask write (0x020 low word, 0x024 high word, bit = 1 masks) takes effect at once. Bits going from masked to unmasked that have a pending request enter service. Bits going from unmasked to masked leave service.
- R5: A write to the clear register (0x080 low word, 0x084 high word) acts only when at least one written bit is in edge mode. Every written bit then loses its request and its in-service state. Otherwise the write has no effect.
- R6: The status register (0x3A0/0x3A4) reads as in-service AND NOT mask. A write to it overwrites that word of the in-service bits.
- R7: Writing one word of a 64-bit register (mask, enable 0x040/0x044, mode, status, polarity 0x3E0/0x3E4) leaves the other word unchanged, and the written value reads back.
- R8: Route bytes sit at 0x100+i and vector bytes at 0x200+i (i = 0..63), in data bits 7:0. After reset every route byte is 1 and every vector byte is 0.
- R9: After reset the mask is all ones. Mode, enable, status, polarity, requests and outputs are all zero.
- R10: 0x000 reads 0x00700001 and 0x004 reads 0x003F0000. The control words at 0x0C0/0x0C4/0x0E0/0x0E4 read zero and ignore writes. Any unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt input levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | 64 | Steered interrupt lines |

## Verification
The hardest state to reach from the ports is an edge-mode request that stays pending after its input has fallen while unmasked. That request can only show up when a later mask write releases it. To reach it, the stimulus raises and drops the edge input, masks everything, and then unmasks only that input. The status read and the steered line confirm that the latched request was delivered. The stimulus then retires the request through the clear register and repeats the unmask, to show that the request is gone. A clear that selects only a level-mode bit must leave the status unchanged, and that is checked as well.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int IRQ_N  = 64;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = $clog2(IRQ_N);
  localparam int SLOT_W = ADDR_W - 3;

  // word-pair slots (address bits 11:3)
  localparam logic [SLOT_W-1:0] SL_IDENT  = 9'h000;
  localparam logic [SLOT_W-1:0] SL_MASK   = 9'h004;
  localparam logic [SLOT_W-1:0] SL_ENABLE = 9'h008;
  localparam logic [SLOT_W-1:0] SL_MODE   = 9'h00C;
  localparam logic [SLOT_W-1:0] SL_CLEAR  = 9'h010;
  localparam logic [SLOT_W-1:0] SL_STATUS = 9'h074;
  localparam logic [SLOT_W-1:0] SL_POLAR  = 9'h07C;
  // byte-table blocks (address bits 11:6)
  localparam logic [ADDR_W-7:0] BLK_ROUTE = 6'h04;
  localparam logic [ADDR_W-7:0] BLK_VECT  = 6'h08;

  localparam logic [WORD_W-1:0] IDENT_LO = 32'h0070_0001;
  localparam logic [WORD_W-1:0] IDENT_HI = {8'h00, 8'(IRQ_N - 1), 16'h0000};

  function automatic logic [IRQ_N-1:0] merge_word(input logic [IRQ_N-1:0] cur,
                                                  input logic [WORD_W-1:0] d,
                                                  input logic hi);
    return hi ? {d, cur[WORD_W-1:0]} : {cur[IRQ_N-1:WORD_W], d};
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [IRQ_N-1:0] v,
                                                  input logic hi);
    return hi ? v[IRQ_N-1:WORD_W] : v[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_vector_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [WORD_W-1:0]          reg_wdata,
  input  logic [IRQ_N-1:0]           isr_q,
  output logic [WORD_W-1:0]          reg_rdata,
  output logic [IRQ_N-1:0]           mask_q,
  output logic [IRQ_N-1:0]           mask_d,
  output logic [IRQ_N-1:0]           edge_q,
  output logic [IRQ_N-1:0][7:0]      vect_q,
  output logic                       clr_fire,
  output logic [IRQ_N-1:0]           clr_bits,
  output logic                       stat_wr
);
  logic [IRQ_N-1:0]      enable_q, polar_q;
  logic [IRQ_N-1:0][7:0] route_q;
  logic [SLOT_W-1:0]     slot;
  logic                  hi, aligned;
  logic [IDX_W-1:0]      bidx;

  assign slot    = reg_addr[ADDR_W-1:3];
  assign hi      = reg_addr[2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign bidx    = reg_addr[IDX_W-1:0];

  function automatic logic hit(input logic [SLOT_W-1:0] s);
    return reg_wr && aligned && (slot == s);
  endfunction

  always_comb begin
    mask_d   = hit(SL_MASK) ? merge_word(mask_q, reg_wdata, hi) : mask_q;
    clr_bits = hi ? {reg_wdata, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, reg_wdata};
    clr_fire = hit(SL_CLEAR) && |(clr_bits & edge_q);
    stat_wr  = hit(SL_STATUS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      enable_q <= '0;
      edge_q   <= '0;
      polar_q  <= '0;
      for (int i = 0; i < IRQ_N; i++) begin
        route_q[i] <= 8'd1;
        vect_q[i]  <= 8'd0;
      end
    end else begin
      mask_q <= mask_d;
      if (hit(SL_ENABLE)) enable_q <= merge_word(enable_q, reg_wdata, hi);
      if (hit(SL_MODE))   edge_q   <= merge_word(edge_q, reg_wdata, hi);
      if (hit(SL_POLAR))  polar_q  <= merge_word(polar_q, reg_wdata, hi);
      if (reg_wr && reg_addr[ADDR_W-1:6] == BLK_ROUTE) route_q[bidx] <= reg_wdata[7:0];
      if (reg_wr && reg_addr[ADDR_W-1:6] == BLK_VECT)  vect_q[bidx]  <= reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1:6] == BLK_ROUTE)
      reg_rdata = {24'h0, route_q[bidx]};
    else if (reg_addr[ADDR_W-1:6] == BLK_VECT)
      reg_rdata = {24'h0, vect_q[bidx]};
    else if (aligned) begin
      case (slot)
        SL_IDENT:  reg_rdata = hi ? IDENT_HI : IDENT_LO;
        SL_MASK:   reg_rdata = pick_word(mask_q, hi);
        SL_ENABLE: reg_rdata = pick_word(enable_q, hi);
        SL_MODE:   reg_rdata = pick_word(edge_q, hi);
        SL_STATUS: reg_rdata = pick_word(isr_q & ~mask_q, hi);
        SL_POLAR:  reg_rdata = pick_word(polar_q, hi);
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_track.sv
module irq_track
  import irq_vector_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irq_in,
  input  logic [IRQ_N-1:0]  edge_q,
  input  logic [IRQ_N-1:0]  mask_q,
  input  logic [IRQ_N-1:0]  mask_d,
  input  logic              clr_fire,
  input  logic [IRQ_N-1:0]  clr_bits,
  input  logic              stat_wr,
  input  logic              stat_hi,
  input  logic [WORD_W-1:0] stat_data,
  output logic [IRQ_N-1:0]  isr_q
);
  logic [IRQ_N-1:0] irr_q, last_q, irr_n, isr_n, rise, fall, unmasked, masked;

  always_comb begin
    rise     = irq_in & ~last_q;
    fall     = ~irq_in & last_q;
    unmasked = mask_q & ~mask_d;
    masked   = mask_d & ~mask_q;
    irr_n    = (edge_q & (irr_q | rise)) | (~edge_q & irq_in);
    if (clr_fire) irr_n = irr_n & ~clr_bits;
    isr_n = (isr_q | (rise & irr_n & ~mask_q)) & ~fall;
    isr_n = (isr_n | (unmasked & irr_n)) & ~masked;
    if (clr_fire) isr_n = isr_n & ~clr_bits;
    if (stat_wr)  isr_n = merge_word(isr_n, stat_data, stat_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      last_q <= irq_in;
    end
  end
endmodule

// File: rtl/irq_fanout.sv
module irq_fanout
  import irq_vector_pkg::*;
(
  input  logic [IRQ_N-1:0]      isr_q,
  input  logic [IRQ_N-1:0][7:0] vect_q,
  output logic [IRQ_N-1:0]      lines
);
  always_comb begin
    lines = '0;
    for (int i = 0; i < IRQ_N; i++)
      if (isr_q[i] && vect_q[i] < 8'(IRQ_N))
        lines[vect_q[i][IDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vector_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_N-1:0]  irq_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [IRQ_N-1:0]  irq_out
);
  logic [IRQ_N-1:0]      mask_q, mask_d, edge_q, clr_bits, isr_q;
  logic [IRQ_N-1:0][7:0] vect_q;
  logic                  clr_fire, stat_wr;

  irq_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .isr_q(isr_q), .reg_rdata(reg_rdata),
    .mask_q(mask_q), .mask_d(mask_d), .edge_q(edge_q), .vect_q(vect_q),
    .clr_fire(clr_fire), .clr_bits(clr_bits), .stat_wr(stat_wr)
  );

  irq_track u_track (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_q(edge_q),
    .mask_q(mask_q), .mask_d(mask_d), .clr_fire(clr_fire), .clr_bits(clr_bits),
    .stat_wr(stat_wr), .stat_hi(reg_addr[2]), .stat_data(reg_wdata),
    .isr_q(isr_q)
  );

  irq_fanout u_fan (.isr_q(isr_q), .vect_q(vect_q), .lines(irq_out));
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk
  import irq_vector_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [IRQ_N-1:0] irq_out,
  input logic [IRQ_N-1:0] mask_q,
  input logic [IRQ_N-1:0] edge_q,
  input logic [IRQ_N-1:0] isr_q,
  input logic [IRQ_N-1:0] irr_q,
  input logic [IRQ_N-1:0] last_q,
  input logic             clr_fire,
  input logic [IRQ_N-1:0] clr_bits,
  input logic             stat_wr
);
  // R1
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_fire) |-> (((irr_q ^ last_q) & ~$past(edge_q)) == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q == '0) |-> (irq_out == '0));

  // R3
  fall_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stat_wr) && mask_q == $past(mask_q)) |->
      ((isr_q & ~last_q & $past(last_q)) == '0));

  // R4
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_wr) |-> ((isr_q & mask_q & ~$past(mask_q)) == '0));

  // R5
  clear_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_fire) && !$past(stat_wr)) |-> ((isr_q & $past(clr_bits)) == '0));
endmodule

bind irq_vector_ctl irq_vector_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .mask_q(mask_q),
  .edge_q(edge_q), .isr_q(isr_q), .irr_q(u_track.irr_q),
  .last_q(u_track.last_q), .clr_fire(clr_fire), .clr_bits(clr_bits),
  .stat_wr(stat_wr)
);

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] irq_out;
  int          n_chk = 0;
  int          n_bad = 0;

  irq_vector_ctl u_irq_vector_ctl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [7:0]  irq;
    logic [11:0] raddr;
    logic [31:0] rexp;
    logic [7:0]  oexp;
  } step_t;

  localparam int NSTEP = 28;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 12'h200, 32'h5,        8'h00, 12'h200, 32'h5,        8'h00}, // R8
    '{1'b1, 12'h201, 32'h6,        8'h00, 12'h201, 32'h6,        8'h00}, // R8
    '{1'b1, 12'h202, 32'h7,        8'h00, 12'h202, 32'h7,        8'h00}, // R8
    '{1'b1, 12'h060, 32'h2,        8'h00, 12'h060, 32'h2,        8'h00}, // R1
    '{1'b1, 12'h020, 32'hFFFFFFF8, 8'h00, 12'h020, 32'hFFFFFFF8, 8'h00}, // R4
    '{1'b0, 12'h000, 32'h0,        8'h01, 12'h3A0, 32'h1,        8'h20}, // R2 level
    '{1'b0, 12'h000, 32'h0,        8'h03, 12'h3A0, 32'h3,        8'h60}, // R2 edge
    '{1'b0, 12'h000, 32'h0,        8'h01, 12'h3A0, 32'h1,        8'h20}, // R3
    '{1'b1, 12'h020, 32'hFFFFFFF9, 8'h01, 12'h3A0, 32'h0,        8'h00}, // R4 mask
    '{1'b1, 12'h020, 32'hFFFFFFF8, 8'h01, 12'h3A0, 32'h1,        8'h20}, // R4 unmask
    '{1'b1, 12'h020, 32'hFFFFFFFF, 8'h01, 12'h3A0, 32'h0,        8'h00}, // R4
    '{1'b1, 12'h020, 32'hFFFFFFFD, 8'h01, 12'h3A0, 32'h2,        8'h40}, // R1 latched
    '{1'b1, 12'h080, 32'h2,        8'h01, 12'h3A0, 32'h0,        8'h00}, // R5
    '{1'b1, 12'h020, 32'hFFFFFFFF, 8'h01, 12'h3A0, 32'h0,        8'h00}, // R5
    '{1'b1, 12'h020, 32'hFFFFFFFD, 8'h01, 12'h3A0, 32'h0,        8'h00}, // R5 gone
    '{1'b1, 12'h020, 32'hFFFFFFFC, 8'h01, 12'h3A0, 32'h1,        8'h20}, // R4
    '{1'b1, 12'h080, 32'h1,        8'h01, 12'h3A0, 32'h1,        8'h20}, // R5 ignored
    '{1'b1, 12'h3A0, 32'h0,        8'h01, 12'h3A0, 32'h0,        8'h00}, // R6
    '{1'b1, 12'h3A0, 32'h3,        8'h01, 12'h3A0, 32'h3,        8'h60}, // R6
    '{1'b1, 12'h064, 32'hABCD,     8'h01, 12'h060, 32'h2,        8'h60}, // R7
    '{1'b0, 12'h000, 32'h0,        8'h01, 12'h064, 32'hABCD,     8'h60}, // R7
    '{1'b0, 12'h000, 32'h0,        8'h01, 12'h000, 32'h00700001, 8'h60}, // R10
    '{1'b1, 12'h0C0, 32'hFFFF,     8'h01, 12'h0C0, 32'h0,        8'h60}, // R10
    '{1'b0, 12'h000, 32'h0,        8'h01, 12'h105, 32'h1,        8'h60}, // R8
    '{1'b1, 12'h105, 32'h33,       8'h01, 12'h105, 32'h33,       8'h60}, // R8
    '{1'b0, 12'h000, 32'h0,        8'h01, 12'h7F0, 32'h0,        8'h60}, // R10
    '{1'b1, 12'h3E4, 32'h55,       8'h01, 12'h3E4, 32'h55,       8'h60}, // R7
    '{1'b0, 12'h000, 32'h0,        8'h01, 12'h3E0, 32'h0,        8'h60}  // R7
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_addr = a;
    #1 check(req, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reset_checks(input string tag);
    rd({tag, " R9 mask lo"}, 12'h020, 32'hFFFFFFFF);
    rd({tag, " R9 mask hi"}, 12'h024, 32'hFFFFFFFF);
    rd({tag, " R9 mode"},    12'h060, 32'h0);
    rd({tag, " R9 status"},  12'h3A0, 32'h0);
    rd({tag, " R8 route"},   12'h13F, 32'h1);
    rd({tag, " R8 vector"},  12'h23F, 32'h0);
    check({tag, " R9 outputs"}, irq_out, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_checks("reset");

    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk);
      irq_in[7:0] = STEPS[k].irq;
      reg_wr      = STEPS[k].wr;
      reg_addr    = STEPS[k].waddr;
      reg_wdata   = STEPS[k].wdata;
      @(negedge clk);
      reg_wr   = 1'b0;
      reg_addr = STEPS[k].raddr;
      #1;
      check($sformatf("step %0d read", k), {32'h0, reg_rdata}, {32'h0, STEPS[k].rexp});
      check($sformatf("step %0d lines", k), {56'h0, irq_out[7:0]}, {56'h0, STEPS[k].oexp});
    end

    // R7: high mask word write keeps low word; top input steered to top line (R2)
    wr(12'h024, 32'h7FFFFFFF);
    rd("R7 mask lo kept", 12'h020, 32'hFFFFFFFC);
    wr(12'h23F, 32'd63);
    @(negedge clk);
    irq_in[63] = 1'b1;
    @(negedge clk);
    #1 check("R2 line 63 up", {63'h0, irq_out[63]}, 64'h1);
    rd("R6 status hi", 12'h3A4, 32'h80000000);
    // R3: drop input 63
    @(negedge clk);
    irq_in[63] = 1'b0;
    @(negedge clk);
    #1 check("R3 line 63 down", {63'h0, irq_out[63]}, 64'h0);
    // R2: out-of-range vector drives nothing
    wr(12'h200, 32'd200);
    #1 check("R2 vector 200 no line", irq_out, 64'h0000_0000_0000_0040);

    // R9: second reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reset_checks("re-reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule